// File: doc/BRIEF.md
# Exception Qualification and Masking Unit

This block sits between the sources of raw exception conditions and the logic that redirects instruction fetch. Every cycle it looks at the raw requests (system reset, machine check, external interrupt, decrementer, IEEE floating-point enabled, other program exceptions, and its own trace conditions). It weighs them against the enable fields of the machine state register and names at most one exception to take, as a one-hot vector with a valid strobe.

Maskable asynchronous requests that arrive while interrupts are disabled are remembered, not lost. They are reported on held flags until the enable returns. A machine check that arrives while machine checks are disabled sends the core into a sticky checkstop instead. Trace conditions are derived from instruction completion reports and become takeable in the cycle after the instruction completes. Requests for system reset, machine check and program exceptions are levels that their sources keep high until they see the exception taken. External and decrementer requests may be single-cycle pulses.

Top module: `exc_qualify_unit`

## Requirements
- R1: A system reset request is never masked. When checkstop is low it is taken in the same cycle (take_vec bit 0) whatever the enables and older_busy are.
- R2: External (bit 4) and decrementer (bit 5) requests are taken only when en_ext is 1. A request seen while en_ext is 0 is held, shown on ext_held / dec_held from the next cycle, taken once en_ext is 1, and cleared from the held state by being taken.
- R3: A machine check request with en_mck at 1 is taken (bit 1). With en_mck at 0, checkstop goes high in that same cycle and no exception is taken.
- R4: Checkstop stays high until rst_n is asserted, and take_valid stays low while checkstop is high. Held requests remain held during checkstop.
- R5: A floating-point enabled request (req_fp) is ignored when fp_mode is 2'b00. With any other fp_mode value it is taken as a program exception (bit 2). req_prog is taken as bit 2 regardless of fp_mode.
- R6: If step_en is 1 and an instruction completes (insn_done) without a fault (insn_fault 0) and is not a return-from-interrupt (insn_rfi 0), a trace exception (bit 3) becomes takeable from the next cycle on.
- R7: If br_trace_en is 1 and a branch (insn_branch) completes without a fault, a trace exception becomes takeable from the next cycle on. A faulting instruction raises no trace.
- R8: While older_busy is 1, program, trace, external and decrementer exceptions are not taken. They stay waiting; system reset and machine check are unaffected.
- R9: Coinciding takeable requests resolve by fixed priority: reset (bit 0), machine check (1), program/floating-point (2), trace (3), external (4), decrementer (5). take_vec is one-hot or zero, and take_valid is 1 exactly when take_vec is nonzero. A trace that loses stays pending.
- R10: After reset, take_valid, take_vec, ext_held, dec_held and checkstop are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the only way out of checkstop |
| req_reset | input | 1 | System reset condition |
| req_mcheck | input | 1 | Machine check condition |
| req_prog | input | 1 | Non-floating-point program exception condition |
| req_fp | input | 1 | IEEE floating-point enabled exception condition |
| req_ext | input | 1 | External interrupt request |
| req_dec | input | 1 | Decrementer request |
| insn_done | input | 1 | An instruction completes this cycle |
| insn_fault | input | 1 | The completing instruction raised some exception |
| insn_branch | input | 1 | The completing instruction is a branch |
| insn_rfi | input | 1 | The completing instruction is a return-from-interrupt |
| older_busy | input | 1 | An earlier instruction-caused exception is still unhandled |
| en_ext | input | 1 | External/decrementer enable from the state register |
| en_mck | input | 1 | Machine check enable |
| fp_mode | input | 2 | Floating-point exception mode field |
| step_en | input | 1 | Single-step trace enable |
| br_trace_en | input | 1 | Branch trace enable |
| take_valid | output | 1 | An exception is taken this cycle |
| take_vec | output | 6 | One-hot exception taken, bit order per R9 |
| ext_held | output | 1 | A masked external request is being held |
| dec_held | output | 1 | A masked decrementer request is being held |
| checkstop | output | 1 | Sticky checkstop state |

## Verification
The sharpest overlap is a system reset request arriving in the same cycle as a machine check. With machine checks enabled the reset must win, and with them disabled the checkstop must win and suppress even the reset. Both orders are driven in directed cycles and judged on take_vec and checkstop in that cycle. A second overlap is a held external request released by en_ext in the same cycle that a trace or program exception is takeable. Random stimulus with a fixed seed provokes this often, and a bench model derived from the priority rule judges each cycle and checks that the loser stays held.

// File: rtl/exq_pkg.sv
`timescale 1ns/1ps
package exq_pkg;
    localparam int EXC_N     = 6;
    localparam int FP_MODE_W = 2;

    localparam int EXC_RST = 0;
    localparam int EXC_MCK = 1;
    localparam int EXC_PRG = 2;
    localparam int EXC_TRC = 3;
    localparam int EXC_EXT = 4;
    localparam int EXC_DEC = 5;

    typedef struct packed {
        logic ext_pend;
        logic dec_pend;
        logic trc_pend;
        logic chkstop;
    } exq_state_t;
endpackage

// File: rtl/exq_qual.sv
`timescale 1ns/1ps
module exq_qual
    import exq_pkg::*;
(
    input  logic                 req_reset,
    input  logic                 req_mcheck,
    input  logic                 req_prog,
    input  logic                 req_fp,
    input  logic                 req_ext,
    input  logic                 req_dec,
    input  logic                 insn_done,
    input  logic                 insn_fault,
    input  logic                 insn_branch,
    input  logic                 insn_rfi,
    input  logic                 older_busy,
    input  logic                 en_ext,
    input  logic                 en_mck,
    input  logic [FP_MODE_W-1:0] fp_mode,
    input  logic                 step_en,
    input  logic                 br_trace_en,
    input  exq_state_t           state_q,
    output logic [EXC_N-1:0]     qual_vec,
    output logic                 cs_enter,
    output logic                 trace_evt
);
    logic fp_live;
    logic ordered_ok;
    logic clean_done;

    always_comb begin
        fp_live    = req_fp && (fp_mode != '0);
        ordered_ok = !older_busy;
        clean_done = insn_done && !insn_fault;

        qual_vec          = '0;
        qual_vec[EXC_RST] = req_reset;
        qual_vec[EXC_MCK] = req_mcheck && en_mck;
        qual_vec[EXC_PRG] = (req_prog || fp_live) && ordered_ok;
        qual_vec[EXC_TRC] = state_q.trc_pend && ordered_ok;
        qual_vec[EXC_EXT] = (req_ext || state_q.ext_pend) && en_ext && ordered_ok;
        qual_vec[EXC_DEC] = (req_dec || state_q.dec_pend) && en_ext && ordered_ok;

        cs_enter  = req_mcheck && !en_mck;
        trace_evt = clean_done &&
                    ((step_en && !insn_rfi) || (br_trace_en && insn_branch));
    end
endmodule

// File: rtl/exq_pick.sv
`timescale 1ns/1ps
module exq_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    for (genvar i = 0; i < N; i++) begin : g_pick
        if (i == 0) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] && !(|req[i-1:0]);
        end
    end
endmodule

// File: rtl/exq_state.sv
`timescale 1ns/1ps
module exq_state
    import exq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_ext,
    input  logic       req_dec,
    input  logic       trace_evt,
    input  logic       cs_enter,
    input  logic       took_ext,
    input  logic       took_dec,
    input  logic       took_trc,
    output exq_state_t state_q
);
    exq_state_t state_d;

    always_comb begin
        state_d          = state_q;
        state_d.ext_pend = (state_q.ext_pend || req_ext) && !took_ext;
        state_d.dec_pend = (state_q.dec_pend || req_dec) && !took_dec;
        state_d.trc_pend = (state_q.trc_pend && !took_trc) || trace_evt;
        state_d.chkstop  = state_q.chkstop || cs_enter;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/exc_qualify_unit.sv
`timescale 1ns/1ps
module exc_qualify_unit
    import exq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_reset,
    input  logic                 req_mcheck,
    input  logic                 req_prog,
    input  logic                 req_fp,
    input  logic                 req_ext,
    input  logic                 req_dec,
    input  logic                 insn_done,
    input  logic                 insn_fault,
    input  logic                 insn_branch,
    input  logic                 insn_rfi,
    input  logic                 older_busy,
    input  logic                 en_ext,
    input  logic                 en_mck,
    input  logic [FP_MODE_W-1:0] fp_mode,
    input  logic                 step_en,
    input  logic                 br_trace_en,
    output logic                 take_valid,
    output logic [EXC_N-1:0]     take_vec,
    output logic                 ext_held,
    output logic                 dec_held,
    output logic                 checkstop
);
    exq_state_t       state_q;
    logic [EXC_N-1:0] qual_vec;
    logic [EXC_N-1:0] grant_vec;
    logic             cs_enter;
    logic             trace_evt;
    logic             cs_now;

    exq_qual i_qual (
        .req_reset   (req_reset),
        .req_mcheck  (req_mcheck),
        .req_prog    (req_prog),
        .req_fp      (req_fp),
        .req_ext     (req_ext),
        .req_dec     (req_dec),
        .insn_done   (insn_done),
        .insn_fault  (insn_fault),
        .insn_branch (insn_branch),
        .insn_rfi    (insn_rfi),
        .older_busy  (older_busy),
        .en_ext      (en_ext),
        .en_mck      (en_mck),
        .fp_mode     (fp_mode),
        .step_en     (step_en),
        .br_trace_en (br_trace_en),
        .state_q     (state_q),
        .qual_vec    (qual_vec),
        .cs_enter    (cs_enter),
        .trace_evt   (trace_evt)
    );

    exq_pick #(.N(EXC_N)) i_pick (
        .req   (qual_vec),
        .grant (grant_vec)
    );

    always_comb begin
        cs_now     = state_q.chkstop || cs_enter;
        take_vec   = cs_now ? '0 : grant_vec;
        take_valid = |take_vec;
        ext_held   = state_q.ext_pend;
        dec_held   = state_q.dec_pend;
        checkstop  = cs_now;
    end

    exq_state i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_ext   (req_ext),
        .req_dec   (req_dec),
        .trace_evt (trace_evt),
        .cs_enter  (cs_enter),
        .took_ext  (take_vec[EXC_EXT]),
        .took_dec  (take_vec[EXC_DEC]),
        .took_trc  (take_vec[EXC_TRC]),
        .state_q   (state_q)
    );
endmodule

// File: rtl/exq_checker.sv
`timescale 1ns/1ps
module exq_checker
    import exq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_reset,
    input logic                 req_mcheck,
    input logic                 req_prog,
    input logic                 req_fp,
    input logic                 req_ext,
    input logic                 en_ext,
    input logic                 en_mck,
    input logic [FP_MODE_W-1:0] fp_mode,
    input logic                 older_busy,
    input logic                 take_valid,
    input logic [EXC_N-1:0]     take_vec,
    input logic                 ext_held,
    input logic                 checkstop
);
    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_vec) && (take_valid == (take_vec != '0)));

    assert_reset_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_reset && !checkstop) |-> (take_vec == EXC_N'(1)));

    assert_mck_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mcheck && !en_mck) |-> (checkstop && !take_valid));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop |=> checkstop);

    assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop |-> !take_valid);

    assert_ext_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vec[EXC_EXT] || take_vec[EXC_DEC]) |-> en_ext);

    assert_ext_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ext && !en_ext) |=> ext_held);

    assert_fp_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_vec[EXC_PRG] |-> (req_prog || (req_fp && (fp_mode != '0))));

    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        older_busy |-> (take_vec[EXC_N-1:EXC_PRG] == '0));
endmodule

bind exc_qualify_unit exq_checker i_exq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_reset  (req_reset),
    .req_mcheck (req_mcheck),
    .req_prog   (req_prog),
    .req_fp     (req_fp),
    .req_ext    (req_ext),
    .en_ext     (en_ext),
    .en_mck     (en_mck),
    .fp_mode    (fp_mode),
    .older_busy (older_busy),
    .take_valid (take_valid),
    .take_vec   (take_vec),
    .ext_held   (ext_held),
    .checkstop  (checkstop)
);

// File: tb/test_exc_qualify_unit.sv
`timescale 1ns/1ps
module test_exc_qualify_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_reset, req_mcheck, req_prog, req_fp, req_ext, req_dec;
    logic insn_done, insn_fault, insn_branch, insn_rfi, older_busy;
    logic en_ext, en_mck, step_en, br_trace_en;
    logic [1:0] fp_mode;
    logic take_valid, ext_held, dec_held, checkstop;
    logic [5:0] take_vec;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic m_ext, m_dec, m_trc, m_cs;

    always #10 clk = ~clk;

    exc_qualify_unit i_exc_qualify_unit (
        .clk(clk), .rst_n(rst_n),
        .req_reset(req_reset), .req_mcheck(req_mcheck), .req_prog(req_prog),
        .req_fp(req_fp), .req_ext(req_ext), .req_dec(req_dec),
        .insn_done(insn_done), .insn_fault(insn_fault), .insn_branch(insn_branch),
        .insn_rfi(insn_rfi), .older_busy(older_busy), .en_ext(en_ext),
        .en_mck(en_mck), .fp_mode(fp_mode), .step_en(step_en),
        .br_trace_en(br_trace_en), .take_valid(take_valid), .take_vec(take_vec),
        .ext_held(ext_held), .dec_held(dec_held), .checkstop(checkstop)
    );

    function automatic logic cs_expect();
        return m_cs || (req_mcheck && !en_mck);
    endfunction

    function automatic logic [5:0] take_expect();
        logic [5:0] q;
        q[0] = req_reset;
        q[1] = req_mcheck && en_mck;
        q[2] = (req_prog || (req_fp && fp_mode != 2'b00)) && !older_busy;
        q[3] = m_trc && !older_busy;
        q[4] = (req_ext || m_ext) && en_ext && !older_busy;
        q[5] = (req_dec || m_dec) && en_ext && !older_busy;
        if (cs_expect()) return 6'b0;
        for (int i = 0; i < 6; i++) begin
            if (q[i]) return 6'(1 << i);
        end
        return 6'b0;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        req_reset = 0; req_mcheck = 0; req_prog = 0; req_fp = 0;
        req_ext = 0; req_dec = 0; insn_done = 0; insn_fault = 0;
        insn_branch = 0; insn_rfi = 0; older_busy = 0;
        en_ext = 0; en_mck = 1; fp_mode = 2'b00; step_en = 0; br_trace_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        repeat (2) @(negedge clk);
        m_ext = 0; m_dec = 0; m_trc = 0; m_cs = 0;
        rst_n = 1'b1;
    endtask

    // Compare all outputs against the model, then advance one clock.
    task automatic cycle(input string tag);
        logic [5:0] e;
        logic ec;
        #1;
        e  = take_expect();
        ec = cs_expect();
        chk(tag, "take_vec", 32'(take_vec), 32'(e));
        chk(tag, "take_valid", 32'(take_valid), 32'(|e));
        chk(tag, "checkstop", 32'(checkstop), 32'(ec));
        chk(tag, "ext_held", 32'(ext_held), 32'(m_ext));
        chk(tag, "dec_held", 32'(dec_held), 32'(m_dec));
        @(posedge clk);
        m_cs  = ec;
        m_ext = (m_ext || req_ext) && !e[4];
        m_dec = (m_dec || req_dec) && !e[5];
        m_trc = (m_trc && !e[3]) ||
                (insn_done && !insn_fault &&
                 ((step_en && !insn_rfi) || (br_trace_en && insn_branch)));
        @(negedge clk);
    endtask

    // Literal expectation at the current inputs, before the model cycle.
    task automatic look(input string tag, input logic [5:0] ev, input logic ecs);
        #1;
        chk(tag, "take_vec(direct)", 32'(take_vec), 32'(ev));
        chk(tag, "checkstop(direct)", 32'(checkstop), 32'(ecs));
    endtask

    initial begin
        #(100000 * 20);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_sink;
        seed_sink = $urandom(32'd20240611);
        idle();
        m_ext = 0; m_dec = 0; m_trc = 0; m_cs = 0;
        do_reset();

        // R10: quiet after reset
        look("R10", 6'b0, 1'b0);
        chk("R10", "ext_held", 32'(ext_held), 0);
        chk("R10", "dec_held", 32'(dec_held), 0);
        cycle("R10");

        // R2: masked external held for several cycles, then taken on enable
        req_ext = 1; en_ext = 0;
        look("R2", 6'b0, 1'b0);
        cycle("R2");
        req_ext = 0;
        for (int k = 0; k < 4; k++) begin
            chk("R2", "ext_held(wait)", 32'(ext_held), 1);
            cycle("R2");
        end
        req_dec = 1;
        cycle("R2");
        req_dec = 0;
        chk("R2", "dec_held", 32'(dec_held), 1);
        en_ext = 1;
        look("R2", 6'b010000, 1'b0);
        cycle("R2");
        look("R2", 6'b100000, 1'b0);
        chk("R2", "ext_held(after)", 32'(ext_held), 0);
        cycle("R2");
        chk("R2", "dec_held(after)", 32'(dec_held), 0);
        en_ext = 0;

        // R1/R3: reset and machine check together, checks enabled
        req_reset = 1; req_mcheck = 1; en_mck = 1;
        look("R1", 6'b000001, 1'b0);
        cycle("R1");
        req_reset = 0;
        look("R3", 6'b000010, 1'b0);
        cycle("R3");
        req_mcheck = 0;

        // R1: reset ignores busy and all enables
        req_reset = 1; older_busy = 1; en_mck = 0; en_ext = 0;
        look("R1", 6'b000001, 1'b0);
        cycle("R1");
        idle();

        // R5: all four floating-point mode values
        req_fp = 1;
        for (int m = 0; m < 4; m++) begin
            fp_mode = 2'(m);
            look("R5", (m == 0) ? 6'b0 : 6'b000100, 1'b0);
            cycle("R5");
        end
        fp_mode = 2'b00; req_fp = 0; req_prog = 1;
        look("R5", 6'b000100, 1'b0);
        cycle("R5");
        req_prog = 0;

        // R6: single-step trace, including rfi and fault exclusions
        step_en = 1; insn_done = 1;
        cycle("R6");
        insn_done = 0;
        look("R6", 6'b001000, 1'b0);
        cycle("R6");
        insn_done = 1; insn_rfi = 1;
        cycle("R6");
        insn_done = 0; insn_rfi = 0;
        look("R6", 6'b0, 1'b0);
        cycle("R6");
        insn_done = 1; insn_fault = 1;
        cycle("R6");
        insn_done = 0; insn_fault = 0;
        look("R6", 6'b0, 1'b0);
        cycle("R6");
        step_en = 0;

        // R7: branch trace, only on branches
        br_trace_en = 1; insn_done = 1; insn_branch = 1;
        cycle("R7");
        insn_done = 0; insn_branch = 0;
        look("R7", 6'b001000, 1'b0);
        cycle("R7");
        insn_done = 1;
        cycle("R7");
        insn_done = 0;
        look("R7", 6'b0, 1'b0);
        cycle("R7");
        br_trace_en = 0;

        // R8: older exception blocks program and external
        older_busy = 1; req_prog = 1; en_ext = 1; req_ext = 1;
        look("R8", 6'b0, 1'b0);
        cycle("R8");
        req_ext = 0;
        cycle("R8");
        older_busy = 0;
        look("R8", 6'b000100, 1'b0);
        cycle("R8");
        req_prog = 0;
        look("R8", 6'b010000, 1'b0);
        cycle("R8");

        // R9: coinciding program, trace, external, decrementer
        step_en = 1; insn_done = 1;
        cycle("R9");
        step_en = 0; insn_done = 0;
        req_prog = 1; req_ext = 1; req_dec = 1; en_ext = 1;
        look("R9", 6'b000100, 1'b0);
        cycle("R9");
        req_prog = 0; req_ext = 0; req_dec = 0;
        look("R9", 6'b001000, 1'b0);
        cycle("R9");
        look("R9", 6'b010000, 1'b0);
        cycle("R9");
        look("R9", 6'b100000, 1'b0);
        cycle("R9");
        idle();

        // R3/R4: checkstop entry with reset request in the same cycle
        req_reset = 1; req_mcheck = 1; en_mck = 0;
        look("R3", 6'b0, 1'b1);
        cycle("R3");
        req_mcheck = 0; en_mck = 1; req_ext = 1; en_ext = 0;
        look("R4", 6'b0, 1'b1);
        cycle("R4");
        req_reset = 0; req_ext = 0; en_ext = 1; req_prog = 1;
        for (int k = 0; k < 3; k++) begin
            look("R4", 6'b0, 1'b1);
            chk("R4", "ext_held(checkstop)", 32'(ext_held), 1);
            cycle("R4");
        end
        do_reset();
        look("R4", 6'b0, 1'b0);
        cycle("R4");

        // Random mix judged by the model
        for (int n = 0; n < 3000; n++) begin
            req_reset   = ($urandom % 50) == 0;
            req_mcheck  = ($urandom % 25) == 0;
            en_mck      = ($urandom % 6) != 0;
            req_prog    = ($urandom % 10) == 0;
            req_fp      = ($urandom % 6) == 0;
            fp_mode     = 2'($urandom % 4);
            req_ext     = ($urandom % 5) == 0;
            req_dec     = ($urandom % 7) == 0;
            insn_done   = ($urandom % 2) == 0;
            insn_fault  = ($urandom % 6) == 0;
            insn_branch = ($urandom % 3) == 0;
            insn_rfi    = ($urandom % 10) == 0;
            older_busy  = ($urandom % 4) == 0;
            en_ext      = ($urandom % 2) == 0;
            step_en     = ($urandom % 3) == 0;
            br_trace_en = ($urandom % 3) == 0;
            cycle("R9");
            if (m_cs && (($urandom % 4) == 0)) do_reset();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule